// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Arbiter

The arbiter watches a bank of interrupt request lines, one line per vector number. A rising edge on a line sets a pending bit for that vector. Every cycle the arbiter looks at all pending bits and picks one winner. It then presents the winner's vector number and its table fetch address on registered outputs, together with a valid flag. The consumer asserts an acknowledge to retire the granted request. That clears only the granted pending bit, and the arbiter picks again on the same edge.

Arbitration works in two tiers. Each vector has a 2-bit priority level, and the highest level present wins. If several pending vectors share that level, the lowest vector number wins. Vectors 0 and 1 are reserved and never take part. Vectors 2 to 5 are core exceptions pinned at the top level. Every vector from 6 upward has a level that software writes through a small write port, and level 0 turns that vector off.

The fetch address is a writable table base plus twice the vector number, so the table can be relocated. The address is captured when the grant is made.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset `valid_o` is 0, every programmable level is 0 and the table base equals parameter `VBA_RST`.
- R2: A 0-to-1 transition of `irq_i[n]` (n >= 2) seen at a clock edge sets the pending bit for vector n. If nothing is being held, the grant appears on the outputs from that same edge, one clock after the request is presented.
- R3: A pending vector at a higher level (3 > 2 > 1) is granted before any pending vector at a lower level.
- R4: Among pending vectors at the same level, the one with the smallest vector number is granted.
- R5: Vectors 0 and 1 are never latched and never granted.
- R6: Vectors 2 to 5 always arbitrate at level 3. Level writes addressed to vectors 0 to 5 have no effect.
- R7: A vector whose level is 0 is never granted. Its pending bit is kept, and it can be granted once a non-zero level is written.
- R8: `addr_o` equals the table base at grant time plus 2 × `vec_o`. Writing `vba_we_i`/`vba_wdata_i` replaces the base used by later grants.
- R9: While `valid_o` is 1 and `ack_i` is 0, `valid_o`, `vec_o` and `addr_o` hold their values, even if higher-priority requests arrive.
- R10: `ack_i` while `valid_o` is 1 clears the pending bit of the granted vector only. The next winner, or `valid_o` = 0, appears after that same edge.
- R11: When `lvl_we_i` is 1, `lvl_wdata_i` is written into the level of vector `lvl_idx_i` (for index 6 or above). The new level is used from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_VEC (16) | Request lines; bit n is vector n, rising edge latches |
| ack_i | input | 1 | Retires the current grant |
| lvl_we_i | input | 1 | Level write strobe |
| lvl_idx_i | input | VEC_W (4) | Vector whose level is written |
| lvl_wdata_i | input | 2 | New level, 0 = disabled |
| vba_we_i | input | 1 | Table base write strobe |
| vba_wdata_i | input | ADDR_W (21) | New table base |
| valid_o | output | 1 | A grant is presented |
| vec_o | output | VEC_W (4) | Granted vector number |
| addr_o | output | ADDR_W (21) | Table base + 2 × vector |

## Verification
The assertions expect acknowledge to be treated as meaningful only while a grant is shown. They also expect the table base to stay far enough from the top of the address range that base plus twice the vector does not wrap. The random stimulus asserts acknowledge freely, and the bench model ignores it while nothing is granted, exactly as required. Every base it writes stays well below the wrap point. Request lines change rarely, so edges keep arriving while earlier grants are still being held, and level writes also land on the fixed and reserved indices.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_OFF = 2'd0;
  localparam lvl_t LVL_TOP = 2'd3;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N     = 16,
  parameter int RSV_N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_nxt_o
);
  logic [N-1:0] irq_q, pend_q, rise, use_mask;

  for (genvar g = 0; g < N; g++) begin : g_mask
    if (g < RSV_N) begin : g_rsv
      assign use_mask[g] = 1'b0;
    end else begin : g_use
      assign use_mask[g] = 1'b1;
    end
  end

  assign rise       = irq_i & ~irq_q & use_mask;
  assign pend_nxt_o = (pend_q & ~clr_i) | rise;
  assign pend_o     = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_nxt_o;
    end
  end

  assert_rsv_never_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[RSV_N-1:0] == '0);

  assert_clear_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & $past(clr_i & ~rise)) == '0);
endmodule

// File: rtl/irq_level_regs.sv
module irq_level_regs
  import irq_arb_pkg::*;
#(
  parameter int N       = 16,
  parameter int VEC_W   = 4,
  parameter int ADDR_W  = 21,
  parameter int RSV_N   = 2,
  parameter int FIX_HI  = 5,
  parameter logic [ADDR_W-1:0] VBA_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_we_i,
  input  logic [VEC_W-1:0]  lvl_idx_i,
  input  lvl_t              lvl_wdata_i,
  input  logic              vba_we_i,
  input  logic [ADDR_W-1:0] vba_wdata_i,
  output lvl_t [N-1:0]      lvl_o,
  output logic [ADDR_W-1:0] vba_o
);
  logic [ADDR_W-1:0] vba_q;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    if (g < RSV_N) begin : g_rsv
      assign lvl_o[g] = LVL_OFF;
    end else if (g <= FIX_HI) begin : g_fix
      assign lvl_o[g] = LVL_TOP;
    end else begin : g_prog
      lvl_t lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= LVL_OFF;
        else if (lvl_we_i && lvl_idx_i == VEC_W'(g)) lvl_q <= lvl_wdata_i;
      end
      assign lvl_o[g] = lvl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vba_q <= VBA_RST;
    else if (vba_we_i) vba_q <= vba_wdata_i;
  end
  assign vba_o = vba_q;

  assert_fixed_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o[FIX_HI] == LVL_TOP && lvl_o[RSV_N] == LVL_TOP);
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VEC_W = 4,
  parameter int RSV_N = 2
) (
  input  logic [N-1:0]     pend_i,
  input  lvl_t [N-1:0]     lvl_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  // descending scan with >= lets the lower index take ties
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_OFF;
    for (int i = N - 1; i >= RSV_N; i--) begin
      if (pend_i[i] && lvl_i[i] != LVL_OFF && lvl_i[i] >= lvl_o) begin
        hit_o = 1'b1;
        idx_o = VEC_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 21,
  parameter int RSV_N   = 2,
  parameter int FIX_HI  = 5,
  parameter logic [ADDR_W-1:0] VBA_RST = 21'h02_0000,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic              ack_i,
  input  logic              lvl_we_i,
  input  logic [VEC_W-1:0]  lvl_idx_i,
  input  logic [1:0]        lvl_wdata_i,
  input  logic              vba_we_i,
  input  logic [ADDR_W-1:0] vba_wdata_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [NUM_VEC-1:0] pend, pend_nxt, clr;
  lvl_t [NUM_VEC-1:0] lvl;
  logic [ADDR_W-1:0]  vba, off;
  logic               sel_hit, load;
  logic [VEC_W-1:0]   sel_idx;
  lvl_t               sel_lvl, lvl_q;
  logic               valid_q;
  logic [VEC_W-1:0]   vec_q;
  logic [ADDR_W-1:0]  addr_q;

  assign load = !valid_q || ack_i;
  assign clr  = (valid_q && ack_i) ? (NUM_VEC'(1) << vec_q) : '0;
  assign off  = {{(ADDR_W-VEC_W-1){1'b0}}, sel_idx, 1'b0};

  irq_pend_latch #(.N(NUM_VEC), .RSV_N(RSV_N)) u_latch (
    .clk_i, .rst_ni, .irq_i, .clr_i(clr), .pend_o(pend), .pend_nxt_o(pend_nxt)
  );

  irq_level_regs #(
    .N(NUM_VEC), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .RSV_N(RSV_N),
    .FIX_HI(FIX_HI), .VBA_RST(VBA_RST)
  ) u_regs (
    .clk_i, .rst_ni, .lvl_we_i, .lvl_idx_i, .lvl_wdata_i,
    .vba_we_i, .vba_wdata_i, .lvl_o(lvl), .vba_o(vba)
  );

  irq_select #(.N(NUM_VEC), .VEC_W(VEC_W), .RSV_N(RSV_N)) u_sel (
    .pend_i(pend_nxt), .lvl_i(lvl), .hit_o(sel_hit), .idx_o(sel_idx), .lvl_o(sel_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      addr_q  <= '0;
      lvl_q   <= LVL_OFF;
    end else if (load) begin
      valid_q <= sel_hit;
      vec_q   <= sel_idx;
      addr_q  <= vba + off;
      lvl_q   <= sel_lvl;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;
  assign addr_o  = addr_q;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(vec_o) && $stable(addr_o));

  assert_no_rsv_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> vec_o >= VEC_W'(RSV_N));

  assert_grant_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pend[vec_o]);

  assert_active_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lvl_q != LVL_OFF);

  assert_addr_even_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(load) |-> addr_o == $past(vba) + {{(ADDR_W-VEC_W-1){1'b0}}, vec_o, 1'b0});
endmodule

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
  localparam int N = 16;
  localparam int AW = 21;
  localparam logic [AW-1:0] VRST = 21'h02_0000;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq = '0;
  logic ack = 0, lwe = 0, vwe = 0;
  logic [3:0] lidx = '0;
  logic [1:0] lwd = '0;
  logic [AW-1:0] vwd = '0;
  logic valid;
  logic [3:0] vec;
  logic [AW-1:0] addr;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [N-1:0] m_pend = '0, m_irq = '0;
  int m_lvl[N];
  logic [AW-1:0] m_vba = VRST, m_addr = '0;
  bit m_valid = 0;
  int m_vec = 0;

  always #5 clk = ~clk;

  irq_prio_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ack_i(ack),
    .lvl_we_i(lwe), .lvl_idx_i(lidx), .lvl_wdata_i(lwd),
    .vba_we_i(vwe), .vba_wdata_i(vwd),
    .valid_o(valid), .vec_o(vec), .addr_o(addr)
  );

  function automatic int eff_lvl(int i);
    if (i < 2) return 0;
    if (i <= 5) return 3;
    return m_lvl[i];
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step(logic [N-1:0] i_irq, bit i_ack, bit i_lwe, int i_idx, int i_lwd,
                      bit i_vwe, logic [AW-1:0] i_vwd, string tag);
    logic [N-1:0] rise, pn;
    int best, bl;
    irq = i_irq; ack = i_ack; lwe = i_lwe; lidx = 4'(i_idx); lwd = 2'(i_lwd);
    vwe = i_vwe; vwd = i_vwd;
    rise = i_irq & ~m_irq & ~16'h0003;
    pn = m_pend;
    if (i_ack && m_valid) pn[m_vec] = 1'b0;
    pn |= rise;
    if (!m_valid || i_ack) begin
      best = -1; bl = 0;
      for (int i = 2; i < N; i++)
        if (pn[i] && eff_lvl(i) > bl) begin best = i; bl = eff_lvl(i); end
      m_valid = (best >= 0);
      if (m_valid) begin m_vec = best; m_addr = m_vba + AW'(2 * best); end
    end
    m_pend = pn;
    if (i_lwe && i_idx >= 6) m_lvl[i_idx] = i_lwd;
    if (i_vwe) m_vba = i_vwd;
    m_irq = i_irq;
    @(posedge clk);
    #2;
    chk({tag, " valid"}, valid, m_valid);
    if (m_valid) begin
      chk({tag, " vec"}, vec, m_vec);
      chk({tag, " addr"}, addr, m_addr);
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", valid, 0);

    step(16'h0100, 0, 0, 0, 0, 0, '0, "R7 level0 ignored");
    chk("R7 no grant", valid, 0);
    step(16'h0100, 0, 1, 8, 1, 0, '0, "R11 write lvl8");
    step(16'h0100, 0, 0, 0, 0, 0, '0, "R11 enabled");
    chk("R11 vec", vec, 8);
    chk("R1 reset base", addr, VRST + 16);
    step(16'h0100, 0, 1, 10, 2, 0, '0, "R9 hold a");
    step(16'h0100, 0, 1, 11, 2, 0, '0, "R9 hold b");
    step(16'h0100, 0, 1, 12, 3, 0, '0, "R9 hold c");
    chk("R9 vec held", vec, 8);
    step(16'h0000, 1, 0, 0, 0, 0, '0, "R10 ack empty");
    chk("R10 empty", valid, 0);
    step(16'h0C00, 0, 0, 0, 0, 0, '0, "R4 tie");
    chk("R4 lowest", vec, 10);
    step(16'h1C00, 0, 0, 0, 0, 0, '0, "R9 preempt held");
    chk("R9 no preempt", vec, 10);
    step(16'h1C00, 1, 0, 0, 0, 0, '0, "R3 level");
    chk("R3 higher level", vec, 12);
    step(16'h1C00, 1, 0, 0, 0, 0, '0, "R10 next");
    chk("R10 next winner", vec, 11);
    step(16'h0003, 1, 0, 0, 0, 0, '0, "R5 reserved");
    chk("R5 none", valid, 0);
    step(16'h0017, 0, 0, 0, 0, 0, '0, "R6 core");
    chk("R6 vec2", vec, 2);
    chk("R2 addr2", addr, VRST + 4);
    step(16'h0017, 1, 0, 0, 0, 0, '0, "R6 core b");
    chk("R6 vec4", addr, VRST + 8);
    step(16'h0000, 1, 1, 3, 0, 0, '0, "R6 write ignored");
    step(16'h0000, 0, 0, 0, 0, 1, 21'h00_1000, "R8 base write");
    step(16'h0008, 0, 0, 0, 0, 0, '0, "R8 relocated");
    chk("R8 addr", addr, 21'h00_1006);
    chk("R6 fixed still", vec, 3);
    step(16'h0000, 1, 0, 0, 0, 0, '0, "R10 drain");

    r = '0;
    for (int k = 0; k < 600; k++) begin
      for (int b = 0; b < N; b++) if ($urandom_range(7) == 0) r[b] = ~r[b];
      step(r, $urandom_range(2) == 0, $urandom_range(3) == 0, $urandom_range(15),
           $urandom_range(3), $urandom_range(40) == 0, AW'($urandom_range(20'hF_0000)),
           "R2 R3 R4 R8 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule